// File: doc/BRIEF.md
# Selectively Protected Register File with In-Word Check Bits

This block is a 64-entry, 64-bit register file with one write port and two independent read ports. It protects narrow values against single-bit upsets without adding any storage for check bits. When a written value has bits 63:52 all at zero, the block computes a single-error-correcting Hamming code over the low 52 bits. It then places the six check bits in the register's own spare upper bits. A one-bit tag kept beside each register records that the register holds an encoded word. Values that use any of the top twelve bits are stored as they are, and their tag is cleared. Negative two's-complement values fall in this group.

On a read, a tagged register passes through a decoder. The decoder corrects a single flipped bit and reports the correction on a per-port pulse. An untagged register is returned as stored, and the decoder's indications stay low. A test-only input flips one chosen bit of one chosen register, so that soft errors can be emulated. Any later write to that register replaces the flipped contents.

Top module: `sprf_top`

## Requirements
- R1: The block holds 64 registers of 64 bits. Both read ports are combinational on their addresses. A write, or an injected flip, becomes visible from the rising edge at which it is sampled.
- R2: A synchronous active-low reset zeroes every register and clears every protection tag. After reset, a read returns the raw stored bits with no decoding.
- R3: A write whose bits 63:52 are all zero sets the tag and stores an encoded word laid out as follows. Data sits in bits 51:0. Check bit j sits in bit 52+j. Bits 63:58 are zero. In the codeword, positions are numbered 1 to 58, check bit j occupies position 2^j, and data bits 0 to 51 fill the remaining positions in ascending order.
- R4: A write with any of bits 63:52 set, including negative values, clears the tag and stores the word unencoded. A read then returns the stored word exactly, flipped bits included, with no correction.
- R5: A read of a tagged register whose stored bits 57:0 hold one flipped bit returns the original 52-bit data, zero-extended, with the port's corrected output at 1. Flips in bits 63:58 of a tagged register have no effect on the output.
- R6: On a tagged read whose syndrome is 59 to 63, the uncorrectable output is 1 and the corrected output is 0. The data is returned without any bit flipped.
- R7: A read of an untagged register never asserts the corrected or uncorrectable output.
- R8: A read of the register being written in the same cycle returns its old contents.
- R9: The two read ports decode and report independently when they read different registers in the same cycle.
- R10: The injection input toggles one bit of one register. A write to that register in the same cycle takes priority, and any later write clears the injected error.
- R11: The value 2^52-1 qualifies for protection and the value 2^52 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Register written |
| wr_data | input | 64 | Value written |
| rda_addr | input | 6 | Read port A register |
| rda_data | output | 64 | Read port A data |
| rda_fixed | output | 1 | Port A: single-bit error corrected |
| rda_bad | output | 1 | Port A: syndrome outside codeword |
| rdb_addr | input | 6 | Read port B register |
| rdb_data | output | 64 | Read port B data |
| rdb_fixed | output | 1 | Port B: single-bit error corrected |
| rdb_bad | output | 1 | Port B: syndrome outside codeword |
| flip_en | input | 1 | Test-only bit-flip strobe |
| flip_addr | input | 6 | Register whose bit is flipped |
| flip_bit | input | 6 | Bit position flipped |

## Verification
The read data and both indications follow the read address in the same cycle, with no register in the path. The bench therefore sets addresses just after a falling edge and samples two nanoseconds later, well before the next rising edge. A write or an injected flip lands at the next rising edge. Each check on its effect is made after that edge, in the following low phase. The read-before-write check samples in the cycle that carries the write strobe, and again one cycle later.

// File: rtl/sprf_pkg.sv
// Shared helpers for the selectively protected register file.
// Assumes codeword positions start at 1 and check bits sit at powers of two.
package sprf_pkg;

    // Codeword position of data bit idx: the idx-th position that is not a power of two.
    function automatic int data_pos(int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < 256; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sprf_encoder.sv
// Hamming SEC encoder: maps DATA_W bits into a CW_LEN-position codeword and
// returns the register image {zeros, check bits, data}.
// Assumes REG_W > DATA_W + CHK_W and 2^CHK_W > DATA_W + CHK_W.
module sprf_encoder #(
    parameter int REG_W  = 64,
    parameter int DATA_W = 52,
    parameter int CHK_W  = 6
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [REG_W-1:0]  word_out
);
    import sprf_pkg::*;
    localparam int CW_LEN = DATA_W + CHK_W;
    localparam int PAD_W  = REG_W - CW_LEN;

    logic [CW_LEN:1]  cw;
    logic [CHK_W-1:0] chk;

    // Scatter the data bits onto their non-power-of-two positions.
    always_comb begin
        cw = '0;
        for (int i = 0; i < DATA_W; i++) cw[data_pos(i)] = data_in[i];
    end

    // Each check bit covers the positions whose index has that bit set.
    always_comb begin
        for (int j = 0; j < CHK_W; j++) begin
            chk[j] = 1'b0;
            for (int p = 1; p <= CW_LEN; p++)
                if (((p >> j) & 1) == 1) chk[j] = chk[j] ^ cw[p];
        end
    end

    assign word_out = {{PAD_W{1'b0}}, chk, data_in};
endmodule

// File: rtl/sprf_decoder.sv
// Hamming SEC decoder for one read port. When prot is low the stored word
// passes through untouched and both indications stay low.
// Assumes the layout produced by sprf_encoder.
module sprf_decoder #(
    parameter int REG_W  = 64,
    parameter int DATA_W = 52,
    parameter int CHK_W  = 6
) (
    input  logic             prot,
    input  logic [REG_W-1:0] word_in,
    output logic [REG_W-1:0] data_out,
    output logic             fixed,
    output logic             bad
);
    import sprf_pkg::*;
    localparam int CW_LEN = DATA_W + CHK_W;

    logic [CW_LEN:1]   cw;
    logic [CW_LEN:1]   cw_fix;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] dec;
    logic              syn_in;
    logic              syn_out;

    // Rebuild the codeword from the stored data and check fields.
    always_comb begin
        cw = '0;
        for (int i = 0; i < DATA_W; i++) cw[data_pos(i)] = word_in[i];
        for (int j = 0; j < CHK_W; j++) cw[1 << j] = word_in[DATA_W + j];
    end

    // Syndrome: parity over the positions each check bit covers.
    always_comb begin
        for (int j = 0; j < CHK_W; j++) begin
            syn[j] = 1'b0;
            for (int p = 1; p <= CW_LEN; p++)
                if (((p >> j) & 1) == 1) syn[j] = syn[j] ^ cw[p];
        end
    end

    assign syn_in  = (syn != '0) && (syn <= CHK_W'(CW_LEN));
    assign syn_out = (syn > CHK_W'(CW_LEN));

    // Flip the position the syndrome names, then gather the data bits.
    always_comb begin
        cw_fix = cw;
        for (int p = 1; p <= CW_LEN; p++)
            if (syn == CHK_W'(p)) cw_fix[p] = ~cw_fix[p];
        for (int i = 0; i < DATA_W; i++) dec[i] = cw_fix[data_pos(i)];
    end

    // Select corrected or raw data and qualify the indications with the tag.
    always_comb begin
        if (prot) begin
            data_out = {{(REG_W - DATA_W){1'b0}}, dec};
            fixed    = syn_in;
            bad      = syn_out;
        end else begin
            data_out = word_in;
            fixed    = 1'b0;
            bad      = 1'b0;
        end
    end
endmodule

// File: rtl/sprf_top.sv
// Register file with per-register protection tags. Narrow writes are encoded
// in place, wide writes are stored raw; reads decode only tagged registers.
// Assumes one write and one optional test flip per cycle; reads are
// combinational and see the contents before the current edge.
module sprf_top #(
    parameter int NUM_REGS = 64,
    parameter int REG_W    = 64,
    parameter int DATA_W   = 52,
    parameter int CHK_W    = 6,
    parameter int ADDR_W   = $clog2(NUM_REGS),
    parameter int BIT_W    = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rda_addr,
    output logic [REG_W-1:0]  rda_data,
    output logic              rda_fixed,
    output logic              rda_bad,
    input  logic [ADDR_W-1:0] rdb_addr,
    output logic [REG_W-1:0]  rdb_data,
    output logic              rdb_fixed,
    output logic              rdb_bad,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [BIT_W-1:0]  flip_bit
);
    localparam int RD_PORTS = 2;
    localparam int HI_W     = REG_W - DATA_W;

    logic [REG_W-1:0]    mem_q [NUM_REGS];
    logic [NUM_REGS-1:0] prot_q;
    logic [REG_W-1:0]    enc_word;
    logic                wr_narrow;

    logic [ADDR_W-1:0] rd_addr_v  [RD_PORTS];
    logic [REG_W-1:0]  rd_data_v  [RD_PORTS];
    logic              rd_fixed_v [RD_PORTS];
    logic              rd_bad_v   [RD_PORTS];

    // Qualify the incoming value: all upper bits clear means it can be encoded.
    assign wr_narrow = (wr_data[REG_W-1:DATA_W] == '0);

    sprf_encoder #(.REG_W(REG_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_in  (wr_data[DATA_W-1:0]),
        .word_out (enc_word)
    );

    // Storage and tags: reset clears all, a flip toggles one bit, a write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
            for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
        end else begin
            if (flip_en) mem_q[flip_addr][flip_bit] <= ~mem_q[flip_addr][flip_bit];
            if (wr_en) begin
                mem_q[wr_addr]  <= wr_narrow ? enc_word : wr_data;
                prot_q[wr_addr] <= wr_narrow;
            end
        end
    end

    assign rd_addr_v[0] = rda_addr;
    assign rd_addr_v[1] = rdb_addr;

    // One decoder per read port, each steered by its register's tag.
    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        sprf_decoder #(.REG_W(REG_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
            .prot     (prot_q[rd_addr_v[g]]),
            .word_in  (mem_q[rd_addr_v[g]]),
            .data_out (rd_data_v[g]),
            .fixed    (rd_fixed_v[g]),
            .bad      (rd_bad_v[g])
        );

        // R5/R6: a read is either corrected or uncorrectable, never both.
        a_r6_fix_bad_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_fixed_v[g] && rd_bad_v[g]));

        // R7: untagged registers never raise decoder indications.
        a_r7_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !prot_q[rd_addr_v[g]] |-> (!rd_fixed_v[g] && !rd_bad_v[g]));

        // R5: tagged reads return zero-extended data.
        a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
            prot_q[rd_addr_v[g]] |-> (rd_data_v[g][REG_W-1:DATA_W] == '0));
    end

    assign rda_data  = rd_data_v[0];
    assign rda_fixed = rd_fixed_v[0];
    assign rda_bad   = rd_bad_v[0];
    assign rdb_data  = rd_data_v[1];
    assign rdb_fixed = rd_fixed_v[1];
    assign rdb_bad   = rd_bad_v[1];

    // R2: the cycle after reset, no register is tagged.
    a_r2_tags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (prot_q == '0));

    // R3: a narrow write leaves its register tagged with zero padding above the code.
    a_r3_narrow_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REG_W-1:DATA_W] == '0) |=>
            (prot_q[$past(wr_addr)] &&
             mem_q[$past(wr_addr)][REG_W-1:DATA_W+CHK_W] == '0));

    // R4: a wide write leaves its register untagged and stored verbatim.
    a_r4_wide_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[REG_W-1:DATA_W] != '0) |=>
            (!prot_q[$past(wr_addr)] && mem_q[$past(wr_addr)] == $past(wr_data)));

    // R10: a same-cycle write beats an injected flip on the same register.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flip_en && wr_addr == flip_addr && wr_data[REG_W-1:DATA_W] != '0) |=>
            (mem_q[$past(wr_addr)] == $past(wr_data)));

    initial begin
        a_r3_layout_fits: assert (HI_W >= CHK_W && (1 << CHK_W) > DATA_W + CHK_W);
    end
endmodule

// File: tb/sprf_top_bench.sv
module sprf_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [5:0]  rda_addr = '0;
    logic [5:0]  rdb_addr = '0;
    logic [63:0] rda_data, rdb_data;
    logic        rda_fixed, rda_bad, rdb_fixed, rdb_bad;
    logic        flip_en = 1'b0;
    logic [5:0]  flip_addr = '0;
    logic [5:0]  flip_bit = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sprf_top u_sprf_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rda_addr(rda_addr), .rda_data(rda_data), .rda_fixed(rda_fixed), .rda_bad(rda_bad),
        .rdb_addr(rdb_addr), .rdb_data(rdb_data), .rdb_fixed(rdb_fixed), .rdb_bad(rdb_bad),
        .flip_en(flip_en), .flip_addr(flip_addr), .flip_bit(flip_bit)
    );

    // {addr, value, flip enable, flip bit}
    localparam logic [76:0] VEC [8] = '{
        {6'd1,  64'h0000_0000_0000_1234, 1'b1, 6'd4},
        {6'd2,  64'h000F_FFFF_FFFF_FFFF, 1'b1, 6'd51},
        {6'd3,  64'h0001_2345_6789_ABCD, 1'b0, 6'd0},
        {6'd4,  64'hDEAD_BEEF_0000_0001, 1'b1, 6'd3},
        {6'd5,  64'hFFFF_FFFF_FFFF_FFFB, 1'b1, 6'd0},
        {6'd6,  64'h0010_0000_0000_0000, 1'b1, 6'd0},
        {6'd63, 64'h0000_0000_0000_0000, 1'b1, 6'd30},
        {6'd0,  64'h000A_5A5A_5A5A_5A5A, 1'b1, 6'd55}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [5:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic inject(logic [5:0] a, logic [5:0] b);
        @(negedge clk);
        flip_en = 1'b1; flip_addr = a; flip_bit = b;
        @(negedge clk);
        flip_en = 1'b0;
    endtask

    task automatic read_both(logic [5:0] a, logic [5:0] b);
        @(negedge clk);
        rda_addr = a; rdb_addr = b;
        #2;
    endtask

    logic [5:0]  v_addr;
    logic [63:0] v_data;
    logic        v_fen;
    logic [5:0]  v_bit;
    logic        v_narrow;
    logic [63:0] v_exp;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state is zero and untagged, so raw bits show through
        read_both(6'd9, 6'd9);
        check("R2 reset data A", rda_data, 64'h0);
        check("R2 reset data B", rdb_data, 64'h0);
        inject(6'd9, 6'd60);
        read_both(6'd9, 6'd9);
        check("R2 raw after reset", rda_data, 64'h1000_0000_0000_0000);
        check("R7 untagged no fix", {62'h0, rda_fixed, rda_bad}, 64'h0);

        // R1 R3 R4 R5 R11: table of writes, optional flips, reads on both ports
        for (int i = 0; i < 8; i++) begin
            v_addr = VEC[i][76:71]; v_data = VEC[i][70:7];
            v_fen  = VEC[i][6];     v_bit  = VEC[i][5:0];
            write_reg(v_addr, v_data);
            if (v_fen) inject(v_addr, v_bit);
            v_narrow = (v_data[63:52] == 12'h0);
            v_exp = v_narrow ? v_data : (v_fen ? (v_data ^ (64'h1 << v_bit)) : v_data);
            read_both(v_addr, v_addr);
            check("R1 R3 R4 R11 data A", rda_data, v_exp);
            check("R9 data B", rdb_data, v_exp);
            check("R5 R7 fixed A", {63'h0, rda_fixed}, {63'h0, v_narrow & v_fen});
            check("R6 bad A", {63'h0, rda_bad}, 64'h0);
        end

        // R6: flips at positions 32 and 27 give syndrome 59
        write_reg(6'd10, 64'h123);
        inject(6'd10, 6'd57);
        inject(6'd10, 6'd21);
        read_both(6'd10, 6'd10);
        check("R6 bad", {63'h0, rda_bad}, 64'h1);
        check("R6 not fixed", {63'h0, rda_fixed}, 64'h0);
        check("R6 data unflipped", rda_data, 64'h123 ^ (64'h1 << 21));

        // R5: flip in padding bits of a tagged register has no effect
        write_reg(6'd10, 64'h456);
        inject(6'd10, 6'd61);
        read_both(6'd10, 6'd10);
        check("R5 padding ignored", rda_data, 64'h456);
        check("R5 padding no fix", {62'h0, rda_fixed, rda_bad}, 64'h0);

        // R10: later write clears injected error
        write_reg(6'd11, 64'h55);
        inject(6'd11, 6'd2);
        write_reg(6'd11, 64'h66);
        read_both(6'd11, 6'd11);
        check("R10 overwrite data", rda_data, 64'h66);
        check("R10 overwrite no fix", {63'h0, rda_fixed}, 64'h0);

        // R10: write and flip in the same cycle, the write wins (wide value shows any flip)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd12; wr_data = 64'hF000_0000_0000_0077;
        flip_en = 1'b1; flip_addr = 6'd12; flip_bit = 6'd0;
        @(negedge clk);
        wr_en = 1'b0; flip_en = 1'b0;
        read_both(6'd12, 6'd12);
        check("R10 write wins", rda_data, 64'hF000_0000_0000_0077);

        // R8: read-before-write
        write_reg(6'd13, 64'hAA);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd13; wr_data = 64'hBB; rda_addr = 6'd13;
        #2;
        check("R8 old value", rda_data, 64'hAA);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R1 R8 new value", rda_data, 64'hBB);

        // R9: independent ports, one corrected and one clean
        inject(6'd13, 6'd7);
        read_both(6'd13, 6'd3);
        check("R9 port A data", rda_data, 64'hBB);
        check("R9 port A fixed", {63'h0, rda_fixed}, 64'h1);
        check("R9 port B data", rdb_data, 64'h0001_2345_6789_ABCD);
        check("R9 port B clean", {63'h0, rdb_fixed}, 64'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule